// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the chip select, the three strobes, the bank select and the address pins. From these it decodes the command being applied. It reports that command one cycle later on registered outputs, together with the target bank, the address field that the command carries, and the modifier flags. The modifier flags are auto-precharge for column accesses and precharge-all for precharge.

For each bank, the block records whether the bank is idle or active and which row it opened. Both are visible at all times on the port, together with a mode register that captures the op-code of a mode-register-set. Illegal accesses are flagged on an error output and leave the bank state untouched. These are a column access to an idle bank and an activate to a bank that is already open.

A low clock enable suspends the block. The enable is sampled on an edge, and from the following edge on every register holds its value until an edge follows one at which the enable was sampled high again.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Inputs are sampled only on the rising clock edge, and the decoded result of the command at edge k is visible on the outputs right after edge k and held until the next processed edge.
- R2: With cs_n sampled high the cycle decodes as no-operation (cmd_o = 0) whatever the strobes carry, and no bank state changes.
- R3: cs_n=0, ras_n=0, cas_n=1, we_n=1 is activate (cmd_o = 1). It makes the bank given by ba active and stores addr[12:0] as that bank's open row. The row appears in open_rows_o at bit offset 13*bank, and addr_o shows the row.
- R4: cs_n=0, ras_n=0, cas_n=1, we_n=0 is precharge (cmd_o = 2). With addr[10]=0 only bank ba goes idle. With addr[10]=1 all banks go idle whatever ba holds, and pre_all_o is 1.
- R5: cs_n=0, ras_n=1, cas_n=0 is a column access: we_n=1 is read (cmd_o = 3) and we_n=0 is write (cmd_o = 4).
- R6: For a read or write, addr_o carries addr[8:0] zero-extended, and the upper address bits are ignored. If addr[10]=1 and the bank is active, auto_pre_o is 1 and the bank is idle after the access.
- R7: cs_n=0 with ras_n, cas_n and we_n all 0 is mode-register-set (cmd_o = 5). mode_o takes addr[12:0], and addr_o shows it as well.
- R8: If cke is sampled low at edge k, the command at edge k still takes effect. At every later edge until one that follows a high sample of cke, all outputs and all state hold.
- R9: A read or write to an idle bank sets err_o and changes no bank state, and auto_pre_o stays 0.
- R10: An activate to an active bank sets err_o and leaves that bank's stored row unchanged.
- R11: cs_n=0 with ras_n, cas_n and we_n all 1, and every code not listed above, decode as no-operation (cmd_o = 0). For these, addr_o is 0 and no state changes.
- R12: A synchronous reset (rst high at an edge) makes all banks idle, clears the stored rows and mode_o to 0, and sets cmd_o, addr_o, err_o and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low suspends from the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column, modifier and op-code bits |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank sampled with the command |
| addr_o | output | 13 | Address field carried by the command |
| auto_pre_o | output | 1 | Column access closes its bank |
| pre_all_o | output | 1 | Precharge applies to all banks |
| err_o | output | 1 | Illegal access rejected |
| bank_active_o | output | 4 | Active flag, one bit per bank |
| open_rows_o | output | 52 | Stored rows, 13 bits per bank |
| mode_o | output | 13 | Mode register contents |

## Verification
Clock suspension and command decoding can meet in one cycle. A command can be applied on the same edge at which cke is first sampled low, and a further command can arrive while the block is frozen. The bench drops cke together with an activate, then issues an activate to another bank during the suspended cycle, and later raises cke again to issue a column access. The scoreboard expects the first activate to take effect, the second to leave every output and bank flag unchanged, and the column access to be decoded normally once the edge after the high sample of cke arrives.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_PRE = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4,
      CMD_MRS = 3'd5
   } cmd_e;

   localparam int unsigned CMD_BITS = 3;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   logic [3:0] code;

   assign code = {cs_n, ras_n, cas_n, we_n};

   always_comb begin
      unique casez (code)
         4'b1???: cmd = CMD_NOP;
         4'b0011: cmd = CMD_ACT;
         4'b0010: cmd = CMD_PRE;
         4'b0101: cmd = CMD_RD;
         4'b0100: cmd = CMD_WR;
         4'b0000: cmd = CMD_MRS;
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
   parameter int unsigned ROW_BITS = 13
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic                act_sel,
   input  logic                pre_sel,
   input  logic                ap_close,
   input  logic [ROW_BITS-1:0] row_in,
   output logic                active,
   output logic [ROW_BITS-1:0] row
);

   initial begin
      assert (ROW_BITS >= 1) else $error("ROW_BITS must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         row    <= '0;
      end else if (en) begin
         if (act_sel && !active) begin
            active <= 1'b1;
            row    <= row_in;
         end else if (pre_sel || ap_close) begin
            active <= 1'b0;
         end
      end
   end

   // R3
   act_open_chk: assert property (@(posedge clk) disable iff (rst)
      (en && act_sel && !active) |=> (active && row == $past(row_in)));

   // R10
   dup_act_chk: assert property (@(posedge clk) disable iff (rst)
      (en && act_sel && active) |=> $stable(row));

   // R8
   bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!en) |=> ($stable(active) && $stable(row)));

endmodule

// File: rtl/sdcmd_mode.sv
module sdcmd_mode #(
   parameter int unsigned MODE_BITS = 13
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic                 load,
   input  logic [MODE_BITS-1:0] din,
   output logic [MODE_BITS-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (en && load)
         q <= din;
   end

   // R7
   mode_load_chk: assert property (@(posedge clk) disable iff (rst)
      (en && load) |=> (q == $past(din)));

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load || !en) |=> $stable(q));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdcmd_pkg::*;
#(
   parameter int unsigned BANK_BITS = 2,
   parameter int unsigned ADDR_BITS = 13,
   parameter int unsigned ROW_BITS  = 13,
   parameter int unsigned COL_BITS  = 9,
   parameter int unsigned AP_BIT    = 10,
   localparam int unsigned NUM_BANKS = 1 << BANK_BITS,
   localparam int unsigned ROWS_W    = NUM_BANKS * ROW_BITS
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BANK_BITS-1:0] ba,
   input  logic [ADDR_BITS-1:0] addr,
   output logic [CMD_BITS-1:0]  cmd_o,
   output logic [BANK_BITS-1:0] bank_o,
   output logic [ADDR_BITS-1:0] addr_o,
   output logic                 auto_pre_o,
   output logic                 pre_all_o,
   output logic                 err_o,
   output logic [NUM_BANKS-1:0] bank_active_o,
   output logic [ROWS_W-1:0]    open_rows_o,
   output logic [ADDR_BITS-1:0] mode_o
);

   initial begin
      assert (ROW_BITS <= ADDR_BITS) else $error("row wider than address bus");
      assert (COL_BITS <= ADDR_BITS) else $error("column wider than address bus");
      assert (AP_BIT < ADDR_BITS) else $error("modifier bit outside address bus");
      assert (AP_BIT >= COL_BITS) else $error("modifier bit overlaps column");
      assert (BANK_BITS >= 1 && BANK_BITS <= 4) else $error("BANK_BITS out of range");
   end

   // clock enable takes effect one edge after it is sampled
   logic cke_q;
   always_ff @(posedge clk) cke_q <= cke;

   cmd_e cmd;
   sdcmd_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   logic                 mod_bit;
   logic                 is_col;
   logic                 tgt_active;
   logic                 col_err;
   logic                 act_err;
   logic [NUM_BANKS-1:0] act_sel;
   logic [NUM_BANKS-1:0] pre_sel;
   logic [NUM_BANKS-1:0] ap_close;
   logic [ADDR_BITS-1:0] addr_nx;
   logic [ADDR_BITS-1:0] col_ext;
   logic [ADDR_BITS-1:0] row_ext;

   assign mod_bit    = addr[AP_BIT];
   assign is_col     = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign tgt_active = bank_active_o[ba];
   assign col_err    = is_col && !tgt_active;
   assign act_err    = (cmd == CMD_ACT) && tgt_active;

   generate
      if (COL_BITS < ADDR_BITS) begin : g_col_pad
         assign col_ext = {{(ADDR_BITS-COL_BITS){1'b0}}, addr[COL_BITS-1:0]};
      end else begin : g_col_full
         assign col_ext = addr;
      end
      if (ROW_BITS < ADDR_BITS) begin : g_row_pad
         assign row_ext = {{(ADDR_BITS-ROW_BITS){1'b0}}, addr[ROW_BITS-1:0]};
      end else begin : g_row_full
         assign row_ext = addr;
      end
   endgenerate

   always_comb begin
      unique case (cmd)
         CMD_ACT:        addr_nx = row_ext;
         CMD_RD, CMD_WR: addr_nx = col_ext;
         CMD_MRS:        addr_nx = addr;
         default:        addr_nx = '0;
      endcase
   end

   // per-bank state cells
   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         assign hit         = (ba == BANK_BITS'(b));
         assign act_sel[b]  = (cmd == CMD_ACT) && hit;
         assign pre_sel[b]  = (cmd == CMD_PRE) && (hit || mod_bit);
         assign ap_close[b] = is_col && hit && tgt_active && mod_bit;

         sdcmd_bank #(.ROW_BITS(ROW_BITS)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .en      (cke_q),
            .act_sel (act_sel[b]),
            .pre_sel (pre_sel[b]),
            .ap_close(ap_close[b]),
            .row_in  (addr[ROW_BITS-1:0]),
            .active  (bank_active_o[b]),
            .row     (open_rows_o[b*ROW_BITS +: ROW_BITS])
         );
      end
   endgenerate

   sdcmd_mode #(.MODE_BITS(ADDR_BITS)) u_mode (
      .clk (clk),
      .rst (rst),
      .en  (cke_q),
      .load(cmd == CMD_MRS),
      .din (addr),
      .q   (mode_o)
   );

   // registered command report
   cmd_e cmd_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q      <= CMD_NOP;
         bank_o     <= '0;
         addr_o     <= '0;
         auto_pre_o <= 1'b0;
         pre_all_o  <= 1'b0;
         err_o      <= 1'b0;
      end else if (cke_q) begin
         cmd_q      <= cmd;
         bank_o     <= ba;
         addr_o     <= addr_nx;
         auto_pre_o <= is_col && tgt_active && mod_bit;
         pre_all_o  <= (cmd == CMD_PRE) && mod_bit;
         err_o      <= col_err || act_err;
      end
   end

   assign cmd_o = cmd_q;

   // R2
   desel_nop_chk: assert property (@(posedge clk) disable iff (rst)
      (cke_q && cs_n) |=> (cmd_o == CMD_NOP && $stable(bank_active_o)));

   // R4
   pre_all_chk: assert property (@(posedge clk) disable iff (rst)
      pre_all_o |-> (bank_active_o == '0));

   // R9
   col_err_chk: assert property (@(posedge clk) disable iff (rst)
      (cke_q && col_err) |=> (err_o && !auto_pre_o && $stable(bank_active_o)));

   // R6
   auto_close_chk: assert property (@(posedge clk) disable iff (rst)
      auto_pre_o |-> !bank_active_o[bank_o]);

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (!cke_q) |=> ($stable(cmd_o) && $stable(addr_o) && $stable(err_o)
                    && $stable(bank_active_o)));

endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB  = 4;
   localparam int RW  = 13;

   typedef struct {
      logic [2:0]      cmd;
      logic [1:0]      bank;
      logic [12:0]     addr;
      logic            ap;
      logic            pa;
      logic            err;
      logic [NB-1:0]   act;
      logic [NB*RW-1:0] rows;
      logic [12:0]     mode;
      string           req;
   } exp_t;

   logic clk = 1'b0;
   logic rst, cke, cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [12:0] addr;
   logic [2:0]  cmd_o;
   logic [1:0]  bank_o;
   logic [12:0] addr_o;
   logic        auto_pre_o, pre_all_o, err_o;
   logic [NB-1:0]    bank_active_o;
   logic [NB*RW-1:0] open_rows_o;
   logic [12:0]      mode_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_cmd_tracker dut_i (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o),
      .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o), .err_o(err_o),
      .bank_active_o(bank_active_o), .open_rows_o(open_rows_o),
      .mode_o(mode_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   exp_t q[$];

   // reference model state
   logic [NB-1:0]    m_act;
   logic [NB*RW-1:0] m_rows;
   logic [12:0]      m_mode;
   logic             m_cke_q;
   exp_t             m_last;

   task automatic compare(input exp_t e);
      n_cmp++;
      if (cmd_o !== e.cmd || bank_o !== e.bank || addr_o !== e.addr ||
          auto_pre_o !== e.ap || pre_all_o !== e.pa || err_o !== e.err ||
          bank_active_o !== e.act || open_rows_o !== e.rows || mode_o !== e.mode) begin
         n_bad++;
         $display("FAIL %s: got cmd=%0d ba=%0d a=%h ap=%b pa=%b err=%b act=%b rows=%h mode=%h exp cmd=%0d ba=%0d a=%h ap=%b pa=%b err=%b act=%b rows=%h mode=%h",
                  e.req, cmd_o, bank_o, addr_o, auto_pre_o, pre_all_o, err_o,
                  bank_active_o, open_rows_o, mode_o,
                  e.cmd, e.bank, e.addr, e.ap, e.pa, e.err, e.act, e.rows, e.mode);
      end
   endtask

   // driver: applies one cycle of pins and pushes the expected result
   task automatic drive(input logic k, input logic [3:0] code,
                        input logic [1:0] b, input logic [12:0] a,
                        input string req);
      exp_t e;
      logic [2:0] c;
      @(negedge clk);
      cke = k; {cs_n, ras_n, cas_n, we_n} = code; ba = b; addr = a;
      case (code)
         4'b0011: c = 3'd1;
         4'b0010: c = 3'd2;
         4'b0101: c = 3'd3;
         4'b0100: c = 3'd4;
         4'b0000: c = 3'd5;
         default: c = 3'd0;
      endcase
      e = m_last;
      if (m_cke_q) begin
         e.cmd = c; e.bank = b; e.addr = '0;
         e.ap = 1'b0; e.pa = 1'b0; e.err = 1'b0;
         case (c)
            3'd1: begin
               e.addr = a;
               if (m_act[b]) e.err = 1'b1;
               else begin m_act[b] = 1'b1; m_rows[b*RW +: RW] = a; end
            end
            3'd2: begin
               if (a[10]) begin e.pa = 1'b1; m_act = '0; end
               else m_act[b] = 1'b0;
            end
            3'd3, 3'd4: begin
               e.addr = {4'd0, a[8:0]};
               if (!m_act[b]) e.err = 1'b1;
               else if (a[10]) begin e.ap = 1'b1; m_act[b] = 1'b0; end
            end
            3'd5: begin e.addr = a; m_mode = a; end
            default: ;
         endcase
         e.act = m_act; e.rows = m_rows; e.mode = m_mode;
      end
      e.req = req;
      m_last = e;
      m_cke_q = k;
      q.push_back(e);
   endtask

   // monitor: pops one expectation per edge, samples after the edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) compare(q.pop_front());
   end

   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_PRE = 4'b0010,
                          C_RD  = 4'b0101, C_WR  = 4'b0100, C_MRS = 4'b0000,
                          C_REF = 4'b0001, C_BST = 4'b0110;

   initial begin
      exp_t r;
      rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      ba = '0; addr = '0;
      m_act = '0; m_rows = '0; m_mode = '0; m_cke_q = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      r = '{cmd:3'd0, bank:2'd0, addr:13'd0, ap:1'b0, pa:1'b0, err:1'b0,
            act:'0, rows:'0, mode:13'd0, req:"R12"};
      compare(r);
      m_last = r;
      rst = 1'b0;

      // R2: deselected cycle carrying an activate code
      drive(1, 4'b1011, 2'd1, 13'h1ABC, "R2");
      // R3: activate bank 1
      drive(1, C_ACT, 2'd1, 13'h1ABC, "R3");
      // R10: second activate to open bank 1 keeps row
      drive(1, C_ACT, 2'd1, 13'h0555, "R10");
      // R5 R6: read without modifier, upper bits ignored
      drive(1, C_RD, 2'd1, 13'h19F3, "R5");
      // R6: write with auto-precharge closes bank 1
      drive(1, C_WR, 2'd1, 13'h15A7, "R6");
      // R9: read and write to idle banks
      drive(1, C_RD, 2'd2, 13'h0401, "R9");
      drive(1, C_WR, 2'd1, 13'h0002, "R9");
      // R1: back-to-back activates on three banks
      drive(1, C_ACT, 2'd0, 13'h0011, "R1");
      drive(1, C_ACT, 2'd2, 13'h1FFF, "R1");
      drive(1, C_ACT, 2'd3, 13'h0800, "R1");
      // R4: single-bank precharge
      drive(1, C_PRE, 2'd2, 13'h1BFF, "R4");
      // R11: refresh and burst-stop codes, plain no-op
      drive(1, C_REF, 2'd0, 13'h1FFF, "R11");
      drive(1, C_BST, 2'd3, 13'h0400, "R11");
      drive(1, C_NOP, 2'd1, 13'h0123, "R11");
      // R4: precharge all with bank select 0
      drive(1, C_PRE, 2'd0, 13'h0400, "R4");
      // R7: mode register set
      drive(1, C_MRS, 2'd2, 13'h0231, "R7");
      // R8: cke drops with an activate, which still executes
      drive(0, C_ACT, 2'd0, 13'h0ACE, "R8");
      // R8: frozen cycles ignore commands
      drive(0, C_ACT, 2'd3, 13'h1111, "R8");
      drive(0, C_MRS, 2'd1, 13'h1F00, "R8");
      drive(1, C_PRE, 2'd0, 13'h0400, "R8");
      // R8: resumes; read with auto-precharge to bank 0
      drive(1, C_RD, 2'd0, 13'h05FF, "R8");
      drive(1, C_ACT, 2'd3, 13'h1234, "R3");
      drive(1, C_MRS, 2'd0, 13'h1FFF, "R7");
      drive(1, C_NOP, 2'd0, 13'h0000, "R11");
      repeat (3) @(posedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got running exp finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule